// File: doc/BRIEF.md
# Address Generation and Pointer Unit

This block drives the 16-bit external memory address of a small 8-bit processor. It holds three 16-bit pointers: a program counter, a stack pointer and a general address pointer. Each pointer is stored as a low byte and a high byte, and each byte can be loaded on its own from the internal 8-bit data bus. A 2-bit select field picks which source appears on the address output. One source is indexed: it is the X:Y register pair plus the address pointer, and this sum is formed combinationally on every cycle.

Each cycle the sequencer sets the controls. It can move the program counter forward by one, step the stack pointer up or down, write one pointer byte, and choose the address source. The address output depends only on the current pointer state and the select field. A change of source therefore takes effect in the same cycle and does not change any pointer.

Top module: `addr_gen_unit`

## Requirements
- R1: `asel` chooses the address source. 00 selects the program counter, 01 the stack pointer and 10 the address pointer (high byte : low byte).
- R2: `asel` = 11 drives `{x_val, y_val}` (X is the high byte) plus the address pointer onto `mem_addr`. The sum is taken modulo 2^16.
- R3: When `pc_inc` is 1 and no program-counter byte is written, the program counter advances by one modulo 2^16, with carry from the low byte into the high byte. When `pc_inc` is 0 it holds its value.
- R4: When `sp_en` is 1 and no stack-pointer byte is written, the stack pointer moves by one: up if `sp_up` is 1, down if it is 0. It wraps modulo 2^16 in both directions. When `sp_en` is 0 it holds its value whatever `sp_up` is.
- R5: When `wr_en` is 1, `wr_data` loads the byte chosen by `wr_dst`: 0 program-counter low, 1 program-counter high, 2 stack-pointer low, 3 stack-pointer high, 4 address-pointer low, 5 address-pointer high. The other byte of that pointer is unchanged. Codes 6 and 7 change nothing.
- R6: A program-counter byte write in the same cycle as `pc_inc` wins. The written byte takes the bus value, the other byte holds, and no increment happens.
- R7: A stack-pointer byte write in the same cycle as `sp_en` wins in the same way, and no step happens.
- R8: A synchronous active-high `rst` clears all three pointers to zero. It overrides increments, steps and writes in the same cycle.
- R9: `mem_addr` is combinational from the pointer state and `asel`. Selecting another source never changes any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| asel | input | 2 | Address source select |
| pc_inc | input | 1 | Program-counter increment enable |
| sp_en | input | 1 | Stack-pointer step enable |
| sp_up | input | 1 | Stack-pointer direction, 1 = up |
| wr_en | input | 1 | Pointer byte write enable |
| wr_dst | input | 3 | Pointer byte write target code |
| wr_data | input | 8 | Byte from the internal data bus |
| x_val | input | 8 | X register, high byte of the index pair |
| y_val | input | 8 | Y register, low byte of the index pair |
| mem_addr | output | 16 | External memory address |

## Verification
The bench targets these corner cases:
- **Carry into the program-counter high byte** (12FF to 1300) and **full wrap** from FFFF to 0000. A counter without byte carry would stall at 1200 or keep a stale high byte.
- **Stack-pointer wrap downward from 0000** and back up through zero. A signed or truncated step would land on the wrong value.
- **Indexed sum that overflows 16 bits** (FF20 plus 80F0 gives 8010), and **X and Y in the correct byte order**.
- **A byte write coinciding with an increment or step**. A design with the wrong priority would show the written value plus one.
- **Unused write codes, a change of source while the program counter advances, and a reset while increments and steps are requested**. A faulty decoder would corrupt a pointer, and a weak reset would leave a nonzero pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2 * BYTE_W;
    localparam int DST_W  = 3;
    localparam int NUM_DST = 1 << DST_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [1:0] {
        ASRC_PC  = 2'b00,
        ASRC_SP  = 2'b01,
        ASRC_PTR = 2'b10,
        ASRC_IDX = 2'b11
    } asrc_e;

    typedef enum logic [DST_W-1:0] {
        DST_PCL = 3'd0,
        DST_PCH = 3'd1,
        DST_SPL = 3'd2,
        DST_SPH = 3'd3,
        DST_APL = 3'd4,
        DST_APH = 3'd5
    } dst_e;

    typedef struct packed {
        logic  lo;
        logic  hi;
    } bytewr_t;

    typedef struct packed {
        ptr_t pc;
        ptr_t sp;
        ptr_t ap;
    } ptr_set_t;

    function automatic ptr_t index_sum(byte_t hi, byte_t lo, ptr_t base);
        return ptr_t'({hi, lo} + base);
    endfunction

    function automatic ptr_t step_val(ptr_t cur, logic up);
        return up ? ptr_t'(cur + ptr_t'(1)) : ptr_t'(cur - ptr_t'(1));
    endfunction

endpackage

// File: rtl/agu_wr_decode.sv
module agu_wr_decode
    import agu_pkg::*;
(
    input  logic             wr_en,
    input  logic [DST_W-1:0] wr_dst,
    output logic [NUM_DST-1:0] strobe
);
    for (genvar i = 0; i < NUM_DST; i++) begin : g_dst
        assign strobe[i] = wr_en && (wr_dst == DST_W'(i));
    end
endmodule

// File: rtl/agu_ptr_reg.sv
module agu_ptr_reg
    import agu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bytewr_t wr,
    input  byte_t   wr_byte,
    input  logic    step_en,
    input  logic    step_up,
    output ptr_t    q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr.lo || wr.hi) begin
            if (wr.lo) q[BYTE_W-1:0]     <= wr_byte;
            if (wr.hi) q[PTR_W-1:BYTE_W] <= wr_byte;
        end else if (step_en) begin
            q <= step_val(q, step_up);
        end
    end
endmodule

// File: rtl/agu_addr_mux.sv
module agu_addr_mux
    import agu_pkg::*;
(
    input  asrc_e    sel,
    input  ptr_set_t ptrs,
    input  byte_t    x_val,
    input  byte_t    y_val,
    output ptr_t     addr
);
    always_comb begin
        unique case (sel)
            ASRC_PC:  addr = ptrs.pc;
            ASRC_SP:  addr = ptrs.sp;
            ASRC_PTR: addr = ptrs.ap;
            default:  addr = index_sum(x_val, y_val, ptrs.ap);
        endcase
    end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        asel,
    input  logic              pc_inc,
    input  logic              sp_en,
    input  logic              sp_up,
    input  logic              wr_en,
    input  logic [DST_W-1:0]  wr_dst,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] x_val,
    input  logic [BYTE_W-1:0] y_val,
    output logic [PTR_W-1:0]  mem_addr
);
    logic [NUM_DST-1:0] strobe;
    bytewr_t  pc_wr, sp_wr, ap_wr;
    ptr_t     pc_q, sp_q, ap_q;
    ptr_set_t ptrs;

    agu_wr_decode u_dec (
        .wr_en (wr_en),
        .wr_dst(wr_dst),
        .strobe(strobe)
    );

    assign pc_wr = '{lo: strobe[DST_PCL], hi: strobe[DST_PCH]};
    assign sp_wr = '{lo: strobe[DST_SPL], hi: strobe[DST_SPH]};
    assign ap_wr = '{lo: strobe[DST_APL], hi: strobe[DST_APH]};

    agu_ptr_reg u_pc (
        .clk(clk), .rst(rst), .wr(pc_wr), .wr_byte(wr_data),
        .step_en(pc_inc), .step_up(1'b1), .q(pc_q)
    );

    agu_ptr_reg u_sp (
        .clk(clk), .rst(rst), .wr(sp_wr), .wr_byte(wr_data),
        .step_en(sp_en), .step_up(sp_up), .q(sp_q)
    );

    agu_ptr_reg u_ap (
        .clk(clk), .rst(rst), .wr(ap_wr), .wr_byte(wr_data),
        .step_en(1'b0), .step_up(1'b0), .q(ap_q)
    );

    assign ptrs = '{pc: pc_q, sp: sp_q, ap: ap_q};

    agu_addr_mux u_mux (
        .sel  (asrc_e'(asel)),
        .ptrs (ptrs),
        .x_val(x_val),
        .y_val(y_val),
        .addr (mem_addr)
    );
endmodule

// File: rtl/agu_checker.sv
module agu_checker
    import agu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        asel,
    input logic              pc_inc,
    input logic              sp_en,
    input logic              sp_up,
    input logic              wr_en,
    input logic [DST_W-1:0]  wr_dst,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] x_val,
    input logic [BYTE_W-1:0] y_val,
    input logic [PTR_W-1:0]  mem_addr,
    input logic [PTR_W-1:0]  pc_q,
    input logic [PTR_W-1:0]  sp_q,
    input logic [PTR_W-1:0]  ap_q
);
    logic rst_d;
    logic pc_w, sp_w, ap_w;

    always_ff @(posedge clk) rst_d <= rst;

    assign pc_w = wr_en && (wr_dst == DST_PCL || wr_dst == DST_PCH);
    assign sp_w = wr_en && (wr_dst == DST_SPL || wr_dst == DST_SPH);
    assign ap_w = wr_en && (wr_dst == DST_APL || wr_dst == DST_APH);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (pc_q == '0 && sp_q == '0 && ap_q == '0)); // R8

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pc_w) |=> pc_q == $past(pc_q) + 16'd1); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_inc && !pc_w) |=> $stable(pc_q)); // R3

    AST_SP_UP: assert property (@(posedge clk) disable iff (rst)
        (sp_en && sp_up && !sp_w) |=> sp_q == $past(sp_q) + 16'd1); // R4

    AST_SP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (sp_en && !sp_up && !sp_w) |=> sp_q == $past(sp_q) - 16'd1); // R4

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sp_en && !sp_w) |=> $stable(sp_q)); // R4

    AST_AP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ap_w |=> $stable(ap_q)); // R5

    AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst == DST_PCL && pc_inc) |=>
        (pc_q[BYTE_W-1:0] == $past(wr_data) &&
         pc_q[PTR_W-1:BYTE_W] == $past(pc_q[PTR_W-1:BYTE_W]))); // R6

    AST_SP_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dst == DST_SPH && sp_en) |=>
        (sp_q[PTR_W-1:BYTE_W] == $past(wr_data) &&
         sp_q[BYTE_W-1:0] == $past(sp_q[BYTE_W-1:0]))); // R7

    AST_INDEXED_ADDR: assert property (@(posedge clk) disable iff (rst)
        (asel == 2'b11) |-> mem_addr == ({x_val, y_val} + ap_q)); // R2

    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (asel == 2'b01) |-> mem_addr == sp_q); // R1
endmodule

bind addr_gen_unit agu_checker u_chk (
    .clk(clk), .rst(rst), .asel(asel), .pc_inc(pc_inc), .sp_en(sp_en),
    .sp_up(sp_up), .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
    .x_val(x_val), .y_val(y_val), .mem_addr(mem_addr),
    .pc_q(pc_q), .sp_q(sp_q), .ap_q(ap_q)
);

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  asel = 2'b00;
    logic        pc_inc = 1'b0, sp_en = 1'b0, sp_up = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_dst = 3'd0;
    logic [7:0]  wr_data = 8'h00, x_val = 8'h00, y_val = 8'h00;
    logic [15:0] mem_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        we;
        logic [2:0]  dst;
        logic [7:0]  d;
        logic        pinc;
        logic        sen;
        logic        sup;
        logic [1:0]  as;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 8'h34, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h0034, 4'd5}, // R5 PCL
        '{1'b1, 3'd1, 8'h12, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1234, 4'd5}, // R5 PCH
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1235, 4'd3}, // R3
        '{1'b1, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h12FF, 4'd6}, // R6
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1300, 4'd3}, // R3 carry
        '{1'b1, 3'd2, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 16'h0000, 4'd7}, // R7
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 16'hFFFF, 4'd4}, // R4 wrap down
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 16'h0000, 4'd4}, // R4 wrap up
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 16'h0001, 4'd4}, // R4 up
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd1, 8'h00, 8'h00, 16'h0001, 4'd4}, // R4 hold
        '{1'b1, 3'd4, 8'hF0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, 16'h00F0, 4'd5}, // R5 ADL
        '{1'b1, 3'd5, 8'h80, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, 16'h80F0, 4'd1}, // R1 R5
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd3, 8'h12, 8'h20, 16'h9310, 4'd2}, // R2
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd3, 8'hFF, 8'h20, 16'h8010, 4'd2}, // R2 wrap
        '{1'b1, 3'd6, 8'hAA, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1300, 4'd5}, // R5 code 6
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 16'h0001, 4'd9}, // R9
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1301, 4'd9}, // R9
        '{1'b1, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h0001, 4'd6}, // R6 PCH
        '{1'b1, 3'd3, 8'h7F, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 16'h7F01, 4'd7}, // R7 SPH
        '{1'b1, 3'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h00FF, 4'd5}, // R5
        '{1'b1, 3'd1, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'hFFFF, 4'd5}, // R5
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 16'h0000, 4'd3}, // R3 wrap
        '{1'b1, 3'd7, 8'h55, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, 16'h80F0, 4'd5}  // R5 code 7
    };

    addr_gen_unit uut (
        .clk(clk), .rst(rst), .asel(asel), .pc_inc(pc_inc), .sp_en(sp_en),
        .sp_up(sp_up), .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
        .x_val(x_val), .y_val(y_val), .mem_addr(mem_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [15:0] exp, input int req, input string what);
        checks++;
        if (mem_addr !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, mem_addr, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; pc_inc = 1'b0; sp_en = 1'b0; sp_up = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state seen through each direct source
        asel = 2'd0; #1 check(16'h0000, 8, "reset pc");
        asel = 2'd1; #1 check(16'h0000, 8, "reset sp");
        asel = 2'd2; #1 check(16'h0000, 8, "reset ap");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].we; wr_dst = VEC[i].dst; wr_data = VEC[i].d;
            pc_inc = VEC[i].pinc; sp_en = VEC[i].sen; sp_up = VEC[i].sup;
            asel = VEC[i].as; x_val = VEC[i].x; y_val = VEC[i].y;
            @(posedge clk);
            #1 check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R8 reset wins over increment, step and write
        @(negedge clk);
        rst = 1'b1; pc_inc = 1'b1; sp_en = 1'b1; sp_up = 1'b1;
        wr_en = 1'b1; wr_dst = 3'd5; wr_data = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; idle();
        asel = 2'd0; #1 check(16'h0000, 8, "pc after reset");
        asel = 2'd1; #1 check(16'h0000, 8, "sp after reset");
        asel = 2'd2; #1 check(16'h0000, 8, "ap after reset");
        x_val = 8'hAB; y_val = 8'hCD;
        asel = 2'd3; #1 check(16'hABCD, 2, "index with zero pointer");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL R0 watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule